// File: doc/BRIEF.md
# Parallel Two-Best-of-Twelve Track Sorter

This block receives one event per clock. An event holds up to twelve track candidates. Each candidate has a 31-bit track word, a valid flag and a cancel flag. The cancel flag is raised by neighbouring duplicate-removal logic outside this block. A cancelled candidate is masked out before ranking.

Every remaining candidate gets an 8-bit rank. The rank is taken from the quality and momentum fields of its word. All candidates are compared against each other at once. The highest and the second-highest are chosen, and their complete words are forwarded unchanged on two outputs. Each output has its own valid flag, aligned with its word.

The block is a two-stage pipeline with a fixed latency of two clocks, and it accepts a new event in every cycle. It has no state machine. Its only registers are the two pipeline stages.
- Stage A extracts the ranks, builds the pairwise win matrix and registers the matrix together with the words.
- Stage B turns each matrix row into a placement, multiplexes the two winning words and registers them.

Top module: `duo_track_sorter`

## Requirements
- R1: The best output carries the complete, unchanged 31-bit word of the live candidate with the highest rank. A live candidate is one that is valid and not cancelled.
- R2: The rank of a candidate is {word[30:28], word[27:23]}. Bits 30:28 hold the quality and bits 27:23 hold the momentum, so a higher quality always beats any momentum.
- R3: A candidate whose cancel flag is high is never selected, whatever its rank.
- R4: A candidate whose valid flag is low is never selected. A valid candidate of rank zero can still be selected.
- R5: When two live candidates have equal ranks, the one on the lower input index is placed higher.
- R6: The second output is the highest-ranked live candidate from an input index other than the best one. Its rank never exceeds the rank of the best output, and this holds even when inputs carry identical words.
- R7: With one live candidate, the second output has its valid flag low and its word zero. With none, both outputs are low and zero. The second output is never valid while the best output is not.
- R8: The results for an event appear exactly two clock cycles after the event is presented, and events may arrive back to back in every cycle.
- R9: While reset is held, and in the first two cycles after it is released, both valid flags are low and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_word | input | 12x31 | Packed track words, with candidate i in slice i |
| cand_valid | input | 12 | Candidate present flags |
| cand_cancel | input | 12 | Duplicate-cancel flags from external logic |
| best_valid | output | 1 | The best output holds a track |
| best_word | output | 31 | Word of the highest-ranked live candidate |
| second_valid | output | 1 | The second output holds a track |
| second_word | output | 31 | Word of the next-highest live candidate |

## Verification
Every event's four results are due two clock edges after the event is captured. The bench drives each event on a falling edge. On that same falling edge, before driving, it compares the outputs with the expectation it stored two events earlier, so the check lands one half-period after the output registers update. The first two comparisons after reset expect the idle result, which also checks R9. Because a new event is driven on every cycle, with no gaps, any extra or missing pipeline stage shows up as a mismatch on the very next check.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
    localparam int N_CAND_DEF = 12;
    localparam int WORD_W_DEF = 31;
    localparam int QUAL_W_DEF = 3;
    localparam int PT_W_DEF   = 5;
    localparam int QUAL_LSB_DEF = 28;
    localparam int PT_LSB_DEF   = 23;

    // Output places of the sorter.
    typedef enum logic [0:0] {
        PLACE_BEST   = 1'b0,
        PLACE_SECOND = 1'b1
    } place_e;
endpackage

// File: rtl/rank_extract.sv
module rank_extract #(
    parameter int QUAL_W = 3,
    parameter int PT_W   = 5,
    localparam int KEY_W = QUAL_W + PT_W + 1
) (
    input  logic [QUAL_W-1:0] qual,
    input  logic [PT_W-1:0]   pt,
    input  logic              valid,
    input  logic              cancel,
    output logic [KEY_W-1:0]  key
);
    logic live;

    // A live bit on top keeps a valid rank-zero track above any dead slot.
    always_comb begin
        live = valid & ~cancel;
        if (live) begin
            key = {1'b1, qual, pt};
        end else begin
            key = '0;
        end
    end
endmodule

// File: rtl/beat_matrix.sv
module beat_matrix #(
    parameter int N     = 12,
    parameter int KEY_W = 9
) (
    input  logic [N-1:0][KEY_W-1:0] keys,
    output logic [N-1:0][N-1:0]     beats
);
    // beats[i][j] is high when candidate i is placed above candidate j.
    // Equal keys are resolved in favour of the lower index, so the result
    // is a strict total order.
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                assign beats[i][j] = 1'b0;
            end else if (i < j) begin : g_low
                assign beats[i][j] = (keys[i] >= keys[j]);
            end else begin : g_high
                assign beats[i][j] = (keys[i] > keys[j]);
            end
        end
    end
endmodule

// File: rtl/winner_pick.sv
module winner_pick #(
    parameter int N      = 12,
    parameter int WORD_W = 31,
    parameter int PLACE  = 0
) (
    input  logic [N-1:0][N-1:0]      beats,
    input  logic [N-1:0]             live,
    input  logic [N-1:0][WORD_W-1:0] words,
    output logic                     win_valid,
    output logic [WORD_W-1:0]        win_word
);
    localparam int TARGET = N - 1 - PLACE;

    logic [N-1:0] sel;

    // The candidate that beats exactly TARGET others holds this place.
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = live[i] && ($countones(beats[i]) == TARGET);
    end

    always_comb begin
        win_word = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                win_word = win_word | words[i];
            end
        end
        win_valid = |sel;
    end
endmodule

// File: rtl/duo_track_sorter.sv
module duo_track_sorter
    import sorter_pkg::*;
#(
    parameter int N_CAND   = N_CAND_DEF,
    parameter int WORD_W   = WORD_W_DEF,
    parameter int QUAL_W   = QUAL_W_DEF,
    parameter int PT_W     = PT_W_DEF,
    parameter int QUAL_LSB = QUAL_LSB_DEF,
    parameter int PT_LSB   = PT_LSB_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_CAND-1:0][WORD_W-1:0] cand_word,
    input  logic [N_CAND-1:0]             cand_valid,
    input  logic [N_CAND-1:0]             cand_cancel,
    output logic                          best_valid,
    output logic [WORD_W-1:0]             best_word,
    output logic                          second_valid,
    output logic [WORD_W-1:0]             second_word
);
    localparam int KEY_W = QUAL_W + PT_W + 1;

    // Stage A: rank extraction and all-pairs comparison.
    logic [N_CAND-1:0][KEY_W-1:0]  keys;
    logic [N_CAND-1:0][N_CAND-1:0] beats;

    for (genvar i = 0; i < N_CAND; i++) begin : g_rank
        rank_extract #(
            .QUAL_W (QUAL_W),
            .PT_W   (PT_W)
        ) u_rank (
            .qual   (cand_word[i][QUAL_LSB +: QUAL_W]),
            .pt     (cand_word[i][PT_LSB +: PT_W]),
            .valid  (cand_valid[i]),
            .cancel (cand_cancel[i]),
            .key    (keys[i])
        );
    end

    beat_matrix #(
        .N     (N_CAND),
        .KEY_W (KEY_W)
    ) u_matrix (
        .keys  (keys),
        .beats (beats)
    );

    logic [N_CAND-1:0][N_CAND-1:0] beats_q;
    logic [N_CAND-1:0]             live_q;
    logic [N_CAND-1:0][WORD_W-1:0] words_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
            live_q  <= '0;
            words_q <= '0;
        end else begin
            beats_q <= beats;
            live_q  <= cand_valid & ~cand_cancel;
            words_q <= cand_word;
        end
    end

    // Stage B: placement decode and output multiplexing.
    logic                 place_valid [2];
    logic [WORD_W-1:0]    place_word  [2];

    for (genvar p = 0; p < 2; p++) begin : g_place
        winner_pick #(
            .N      (N_CAND),
            .WORD_W (WORD_W),
            .PLACE  (p)
        ) u_pick (
            .beats     (beats_q),
            .live      (live_q),
            .words     (words_q),
            .win_valid (place_valid[p]),
            .win_word  (place_word[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_valid   <= 1'b0;
            best_word    <= '0;
            second_valid <= 1'b0;
            second_word  <= '0;
        end else begin
            best_valid   <= place_valid[PLACE_BEST];
            best_word    <= place_word[PLACE_BEST];
            second_valid <= place_valid[PLACE_SECOND];
            second_word  <= place_word[PLACE_SECOND];
        end
    end
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk #(
    parameter int N_CAND = 12,
    parameter int WORD_W = 31,
    parameter int RANK_W = 8,
    parameter int RANK_LSB = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CAND-1:0] cand_valid,
    input logic [N_CAND-1:0] cand_cancel,
    input logic              best_valid,
    input logic [WORD_W-1:0] best_word,
    input logic              second_valid,
    input logic [WORD_W-1:0] second_word
);
    logic [1:0]        age;
    logic [N_CAND-1:0] live;

    assign live = cand_valid & ~cand_cancel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R7
    second_needs_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_valid |-> best_valid);

    // R7
    best_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid |-> (best_word == '0));

    // R7
    second_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !second_valid |-> (second_word == '0));

    // R6
    rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_valid |-> (best_word[RANK_LSB +: RANK_W] >= second_word[RANK_LSB +: RANK_W]));

    // R8
    best_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (best_valid == $past(|live, 2)));

    // R8
    second_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (second_valid == $past($countones(live) >= 2, 2)));
endmodule

bind duo_track_sorter sorter_chk #(
    .N_CAND   (N_CAND),
    .WORD_W   (WORD_W),
    .RANK_W   (QUAL_W + PT_W),
    .RANK_LSB (PT_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_valid   (cand_valid),
    .cand_cancel  (cand_cancel),
    .best_valid   (best_valid),
    .best_word    (best_word),
    .second_valid (second_valid),
    .second_word  (second_word)
);

// File: tb/sim_duo_track_sorter.sv
module sim_duo_track_sorter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 12;
    localparam int W = 31;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0][W-1:0]  cw = '0;
    logic [N-1:0]         cv = '0;
    logic [N-1:0]         cc = '0;
    logic                 best_valid, second_valid;
    logic [W-1:0]         best_word, second_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1357_9bdf;

    // Expectations in flight, indexed by event number modulo 4.
    logic         e_bv [4];
    logic [W-1:0] e_bw [4];
    logic         e_sv [4];
    logic [W-1:0] e_sw [4];
    string        e_tag [4];
    int           ev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duo_track_sorter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_word    (cw),
        .cand_valid   (cv),
        .cand_cancel  (cc),
        .best_valid   (best_valid),
        .best_word    (best_word),
        .second_valid (second_valid),
        .second_word  (second_word)
    );

    // Word with a given 8-bit rank in bits 30:23 and a payload below.
    function automatic logic [W-1:0] mk(input int rank, input int pay);
        logic [7:0]  r;
        logic [22:0] p;
        r = rank[7:0];
        p = pay[22:0];
        return {r, p};
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check_out(input int slot);
        checks++;
        if (best_valid !== e_bv[slot] || best_word !== e_bw[slot] ||
            second_valid !== e_sv[slot] || second_word !== e_sw[slot]) begin
            errors++;
            $display("FAIL %s: got best %0b/%h second %0b/%h, expected best %0b/%h second %0b/%h",
                     e_tag[slot], best_valid, best_word, second_valid, second_word,
                     e_bv[slot], e_bw[slot], e_sv[slot], e_sw[slot]);
        end
    endtask

    // Checks the event from two cycles back, then drives the current one.
    task automatic push(input logic [N-1:0][W-1:0] w, input logic [N-1:0] v,
                        input logic [N-1:0] c, input string tag);
        int b;
        int s;
        int slot;
        @(negedge clk);
        check_out((ev + 2) % 4);
        b = -1;
        s = -1;
        for (int i = 0; i < N; i++) begin
            if (v[i] && !c[i]) begin
                if (b < 0 || w[i][30:23] > w[b][30:23]) b = i;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (v[i] && !c[i] && i != b) begin
                if (s < 0 || w[i][30:23] > w[s][30:23]) s = i;
            end
        end
        slot = ev % 4;
        e_bv[slot] = (b >= 0);
        e_bw[slot] = (b >= 0) ? w[b] : '0;
        e_sv[slot] = (s >= 0);
        e_sw[slot] = (s >= 0) ? w[s] : '0;
        e_tag[slot] = tag;
        cw = w;
        cv = v;
        cc = c;
        ev++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0][W-1:0] w;
        logic [N-1:0] v;
        logic [N-1:0] c;
        for (int k = 0; k < 4; k++) begin
            e_bv[k] = 1'b0; e_bw[k] = '0; e_sv[k] = 1'b0; e_sw[k] = '0;
            e_tag[k] = "R9 reset state";
        end
        repeat (3) @(negedge clk);
        // R9: outputs held idle during reset
        checks++;
        if (best_valid !== 1'b0 || best_word !== '0 || second_valid !== 1'b0 || second_word !== '0) begin
            errors++;
            $display("FAIL R9: got %0b/%h %0b/%h, expected 0/0 0/0",
                     best_valid, best_word, second_valid, second_word);
        end
        rst_n = 1'b1;
        ev = 2;

        // R7: no candidates at all
        w = '0;
        for (int i = 0; i < N; i++) w[i] = mk(200 + i, i);
        push(w, '0, '0, "R7 R4 none valid");
        // R3: every candidate cancelled
        push(w, '1, '1, "R3 all cancelled");
        // R7 R1: one live candidate at each index
        for (int i = 0; i < N; i++) begin
            w = '0;
            for (int k = 0; k < N; k++) w[k] = mk(17 * k + 3, 100 + k);
            push(w, N'(1) << i, '0, "R7 R1 single live");
        end
        // R2: quality 1 momentum 31 loses to quality 2 momentum 0
        w = '0;
        w[3] = mk({3'd1, 5'd31}, 3);
        w[7] = mk({3'd2, 5'd0}, 7);
        push(w, 12'h088, '0, "R2 quality dominates");
        // R5: all equal ranks, distinct payloads
        for (int i = 0; i < N; i++) w[i] = mk(90, 500 + i);
        push(w, '1, '0, "R5 tie all");
        push(w, 12'h220, '0, "R5 tie pair");
        // R6: identical words everywhere
        for (int i = 0; i < N; i++) w[i] = mk(90, 7);
        push(w, '1, '0, "R6 identical words");
        // R4: valid rank zero beats invalid high ranks
        for (int i = 0; i < N; i++) w[i] = mk(250, i);
        w[4] = mk(0, 44);
        push(w, 12'h010, '0, "R4 rank zero live");
        w[9] = mk(0, 99);
        push(w, 12'h210, '0, "R4 two rank zero");
        // R6: every ordered pair of live inputs
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i != j) begin
                    for (int k = 0; k < N; k++) w[k] = mk(255, 900 + k);
                    w[i] = mk((i * 37 + j * 11) % 256, i);
                    w[j] = mk((j * 53 + i * 7) % 256, 50 + j);
                    push(w, (N'(1) << i) | (N'(1) << j), '0, "R6 pair sweep");
                end
            end
        end
        // R3: cancel the strongest candidate at each index
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < N; k++) w[k] = mk(10 + k, k);
            w[i] = mk(255, 333);
            push(w, '1, N'(1) << i, "R3 cancel top");
        end
        // R8 R1: back-to-back pseudo-random events
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < N; k++) begin
                lfsr = nxt(lfsr);
                w[k] = lfsr[30:0];
                if (n % 3 == 0) w[k][30:23] = {5'd0, lfsr[2:0]};
            end
            lfsr = nxt(lfsr);
            v = lfsr[11:0] | lfsr[23:12];
            lfsr = nxt(lfsr);
            c = lfsr[11:0] & lfsr[27:16];
            push(w, v, c, "R8 R1 random stream");
        end
        // flush the pipeline
        push('0, '0, '0, "R7 flush");
        push('0, '0, '0, "R7 flush");
        @(negedge clk);
        check_out((ev + 2) % 4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule